// File: doc/BRIEF.md
# Four-Lane Keyed 64-bit Digest Engine

The engine folds two 64-bit operands and a 64-bit key into one 64-bit digest. It first scatters the operand bytes into two 64-bit words, so that every 32-bit half carries bytes of both operands. Each of the four halves then runs through a 32-round, 16-bit-branch Feistel cipher. All four use the same key, but each half reads the expanded key words in its own rotated order. The two ciphered 64-bit words are combined with XOR to form the digest. A typical use is producing and checking return-address signatures: the caller offers the address and a stack value, together with a secret key.

Requests enter on a valid/ready handshake. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops on that edge and stays low until the result is ready, so a source must hold its request until it sees `in_ready`. Requests offered while the engine is busy are not taken and have no effect. There is no back-pressure on the result. `done` pulses high for one cycle, and `digest` then holds its value until the next result replaces it. Four cipher lanes run in parallel, one round per cycle, and share one iterative key schedule.

Top module: `hd_digest4`

## Requirements
- R1: While reset is held (active-low `rst_n`), and after its release until the first result, `done` is 0, `digest` is 0 and `in_ready` is 1.
- R2: The upper mixed word H is built as follows, for i = 0..3. Bits 8i+7:8i of `op_b` are placed at bits 8(7-2i)+7:8(7-2i) of H. Bits 8(4+i)+7:8(4+i) of `op_a` are placed at bits 16i+7:16i of H.
- R3: The lower mixed word L is built as follows, for i = 0..3. Bits 8(4+i)+7:8(4+i) of `op_b` are placed at bits 8(7-2i)+7:8(7-2i) of L. Bits 8i+7:8i of `op_a` are placed at bits 16i+7:16i of L.
- R4: The lane cipher E(x, lane) works as follows.
  - Key words: k0..k3 are `key`[63:48], [47:32], [31:16] and [15:0]. For i = 0..27, let t = ror3(k(i+3)) ^ k(i+1). Then k(i+4) = 0xFFFC ^ z_i ^ k(i) ^ t ^ ror1(t), where z_i is bit 63-i of 0xFA2561CDF44AC398.
  - State: the left half starts as x[15:0] and the right half as x[31:16].
  - Rounds: there are 32 rounds, r = 0..31. Each round does left' = right ^ ((rol1(left) & rol8(left)) ^ rol2(left)) ^ k(4*floor(r/4) + ((r mod 4 + lane) mod 4)), then right' = left.
  - Result: E = {right, left}.
- R5: Four cipher lanes are used, all with the same key. H[63:32] is ciphered with lane 0 and H[31:0] with lane 1. L[63:32] is ciphered with lane 2 and L[31:0] with lane 3. Each result stays in the position its input came from.
- R6: `digest` equals the ciphered H XOR the ciphered L.
- R7: A request is taken only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until `done` is asserted. Requests offered while `in_ready` is 0 change neither the result nor the number of `done` pulses.
- R8: `done` is high for exactly one cycle. It rises 33 clock edges after the edge on which the request was taken.
- R9: `digest` changes only on the edge that raises `done`. Between results it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Engine idle, request can be taken |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| key | input | 64 | Cipher key shared by all lanes |
| done | output | 1 | One-cycle pulse: digest updated |
| digest | output | 64 | Most recent digest |

## Verification
The checker watches the handshake and timing rules on every cycle. It confirms that `in_ready` falls after a request is taken and is high again when `done` appears. It confirms that `done` is a single-cycle pulse arriving exactly 33 edges after the request was taken, and that `digest` never moves outside that pulse. The numeric content of the byte scatter, the key schedule, the lane key rotation and the final XOR can only be shown by the bench's scenarios. These compare each digest against a separately written model, using zero, all-ones, walking-byte and mixed operands, several keys, swapped operands, back-to-back requests and requests offered while busy.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int HALF_W   = 16;
  localparam int LANE_W   = 2 * HALF_W;
  localparam int WORD_W   = 2 * LANE_W;
  localparam int N_LANES  = 4;
  localparam int ROUNDS   = 32;
  localparam int GROUP    = 4;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam int GRP_W    = $clog2(ROUNDS / GROUP);
  localparam logic [HALF_W-1:0] KS_CONST = 16'hfffc;
  localparam logic [63:0]       KS_ZSEQ  = 64'hfa2561cdf44ac398;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [LANE_W-1:0] lane_t;

  function automatic half_t rol(half_t v, int s);
    return (v << s) | (v >> (HALF_W - s));
  endfunction

  function automatic half_t ror(half_t v, int s);
    return (v >> s) | (v << (HALF_W - s));
  endfunction

  function automatic half_t ks_next(half_t a, half_t b, half_t d, logic zb);
    half_t t;
    t = ror(d, 3) ^ b;
    return KS_CONST ^ {{(HALF_W-1){1'b0}}, zb} ^ a ^ t ^ ror(t, 1);
  endfunction

  function automatic half_t mix_f(half_t l);
    return (rol(l, 1) & rol(l, 8)) ^ rol(l, 2);
  endfunction
endpackage

// File: rtl/hd_interleave.sv
module hd_interleave
  import hd_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] word_hi,
  output logic [WORD_W-1:0] word_lo
);
  localparam int NB = WORD_W / 16;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign word_hi[8*(7-2*i) +: 8] = op_b[8*i +: 8];
    assign word_hi[16*i      +: 8] = op_a[8*(NB+i) +: 8];
    assign word_lo[8*(7-2*i) +: 8] = op_b[8*(NB+i) +: 8];
    assign word_lo[16*i      +: 8] = op_a[8*i +: 8];
  end
endmodule

// File: rtl/hd_keysched.sv
module hd_keysched
  import hd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          adv,
  input  logic [WORD_W-1:0]             key,
  output logic [GROUP-1:0][HALF_W-1:0]  win
);
  logic [GRP_W-1:0]            grp_q;
  logic [GROUP-1:0][HALF_W-1:0] nxt;
  logic [GROUP-1:0]            zb;

  for (genvar m = 0; m < GROUP; m++) begin : g_z
    logic [5:0] zi;
    assign zi    = 6'(GROUP * grp_q + m);
    assign zb[m] = KS_ZSEQ[6'd63 - zi];
  end

  always_comb begin
    nxt[0] = ks_next(win[0], win[1], win[3], zb[0]);
    nxt[1] = ks_next(win[1], win[2], nxt[0], zb[1]);
    nxt[2] = ks_next(win[2], win[3], nxt[1], zb[2]);
    nxt[3] = ks_next(win[3], nxt[0], nxt[2], zb[3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win   <= '0;
      grp_q <= '0;
    end else if (load) begin
      for (int j = 0; j < GROUP; j++)
        win[j] <= key[WORD_W-HALF_W*(j+1) +: HALF_W];
      grp_q <= '0;
    end else if (adv) begin
      win   <= nxt;
      grp_q <= grp_q + 1'b1;
    end
  end
endmodule

// File: rtl/hd_lane.sv
module hd_lane
  import hd_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step,
  input  logic [1:0]                    phase,
  input  lane_t                         din,
  input  logic [GROUP-1:0][HALF_W-1:0]  win,
  output lane_t                         dout
);
  localparam logic [1:0] OFS = LANE[1:0];

  half_t left_q, right_q, rkey;
  logic [1:0] sel;

  assign sel  = phase + OFS;
  assign rkey = win[sel];
  assign dout = {right_q, left_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (load) begin
      left_q  <= din[HALF_W-1:0];
      right_q <= din[LANE_W-1:HALF_W];
    end else if (step) begin
      left_q  <= right_q ^ mix_f(left_q) ^ rkey;
      right_q <= left_q;
    end
  end
endmodule

// File: rtl/hd_digest4.sv
module hd_digest4
  import hd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  op_a,
  input  logic [WORD_W-1:0]  op_b,
  input  logic [WORD_W-1:0]  key,
  output logic               done,
  output logic [WORD_W-1:0]  digest
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_t;

  st_t                          st_q;
  logic [RND_W-1:0]             rnd_q;
  logic                         take, step, adv, last;
  logic [WORD_W-1:0]            word_hi, word_lo;
  logic [GROUP-1:0][HALF_W-1:0] win;
  lane_t                        lane_in  [N_LANES];
  lane_t                        lane_out [N_LANES];

  assign in_ready = (st_q == ST_IDLE);
  assign take     = in_valid && in_ready;
  assign step     = (st_q == ST_RUN);
  assign last     = (rnd_q == RND_W'(ROUNDS - 1));
  assign adv      = step && (rnd_q[1:0] == 2'd3) && !last;

  hd_interleave u_mix (
    .op_a(op_a), .op_b(op_b), .word_hi(word_hi), .word_lo(word_lo)
  );

  hd_keysched u_ks (
    .clk(clk), .rst_n(rst_n), .load(take), .adv(adv), .key(key), .win(win)
  );

  assign lane_in[0] = word_hi[WORD_W-1:LANE_W];
  assign lane_in[1] = word_hi[LANE_W-1:0];
  assign lane_in[2] = word_lo[WORD_W-1:LANE_W];
  assign lane_in[3] = word_lo[LANE_W-1:0];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    hd_lane #(.LANE(g)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(take), .step(step),
      .phase(rnd_q[1:0]), .din(lane_in[g]), .win(win), .dout(lane_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      done   <= 1'b0;
      digest <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (take) begin
          st_q  <= ST_RUN;
          rnd_q <= '0;
        end
        ST_RUN: begin
          rnd_q <= rnd_q + 1'b1;
          if (last) st_q <= ST_FIN;
        end
        ST_FIN: begin
          digest <= {lane_out[0], lane_out[1]} ^ {lane_out[2], lane_out[3]};
          done   <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hd_digest4_chk.sv
module hd_digest4_chk
  import hd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic [WORD_W-1:0] digest
);
  localparam int LAT = ROUNDS + 1;

  logic       trk;
  logic [6:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk <= 1'b0;
      cnt <= '0;
    end else if (in_valid && in_ready) begin
      trk <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      trk <= 1'b0;
    end else if (trk) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R7
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk && cnt == 7'(LAT))); // R8
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest)); // R9
endmodule

bind hd_digest4 hd_digest4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .digest(digest)
);

// File: tb/hd_digest4_bench.sv
`timescale 1ns/1ps
module hd_digest4_bench;
  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [63:0] op_a = '0, op_b = '0, key = '0;
  logic        in_ready, done;
  logic [63:0] digest;

  int n_chk = 0, n_fail = 0, cyc = 0, n_done = 0, n_sent = 0;
  logic [63:0] exp_q[$];
  int          acc_q[$];
  logic        prev_done = 0;
  logic [63:0] prev_dig = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hd_digest4 u_hd_digest4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .key(key), .done(done), .digest(digest)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_lane(logic [31:0] x, logic [63:0] k64, int lane);
    logic [15:0] k [32];
    logic [15:0] l, r, t, f, e;
    logic [63:0] zs = 64'hfa2561cdf44ac398;
    k[0] = k64[63:48]; k[1] = k64[47:32]; k[2] = k64[31:16]; k[3] = k64[15:0];
    for (int i = 0; i < 28; i++) begin
      t = {k[i+3][2:0], k[i+3][15:3]} ^ k[i+1];
      k[i+4] = 16'hfffc ^ {15'b0, zs[63-i]} ^ k[i] ^ t ^ {t[0], t[15:1]};
    end
    l = x[15:0]; r = x[31:16];
    for (int i = 0; i < 32; i++) begin
      e = k[4*(i/4) + ((i%4 + lane) % 4)];
      f = ({l[14:0], l[15]} & {l[7:0], l[15:8]}) ^ {l[13:0], l[15:14]};
      t = l; l = r ^ f ^ e; r = t;
    end
    return {r, l};
  endfunction

  function automatic logic [63:0] ref_digest(logic [63:0] a, logic [63:0] b, logic [63:0] k64);
    logic [63:0] h, lw;
    for (int i = 0; i < 4; i++) begin
      h[8*(7-2*i) +: 8]  = b[8*i +: 8];
      h[16*i +: 8]       = a[8*(4+i) +: 8];
      lw[8*(7-2*i) +: 8] = b[8*(4+i) +: 8];
      lw[16*i +: 8]      = a[8*i +: 8];
    end
    return {ref_lane(h[63:32], k64, 0), ref_lane(h[31:0], k64, 1)}
         ^ {ref_lane(lw[63:32], k64, 2), ref_lane(lw[31:0], k64, 3)};
  endfunction

  // driver: R2 R3 R4 R5 R6 expectations pushed per accepted request
  task automatic send(logic [63:0] a, logic [63:0] b, logic [63:0] k64, int busy_junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op_a = a; op_b = b; key = k64; in_valid = 1;
    exp_q.push_back(ref_digest(a, b, k64));
    @(negedge clk);
    acc_q.push_back(cyc);
    n_sent++;
    if (busy_junk > 0) begin
      op_a = ~a; op_b = a ^ b; key = k64 + 64'h1; // offered while busy: R7
      repeat (busy_junk) @(negedge clk);
    end
    in_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        chk(!done, "R8 pulse width", {63'b0, done}, 64'h0);
        chk(digest == prev_dig, "R9 digest hold", digest, prev_dig);
      end
      if (done) begin
        n_done++;
        if (exp_q.size() == 0) chk(0, "R7 unexpected done", digest, 64'h0);
        else begin
          logic [63:0] e;
          int a0;
          e  = exp_q.pop_front();
          a0 = acc_q.pop_front();
          chk(digest == e, "R6 digest value (R2 R3 R4 R5)", digest, e);
          chk(cyc - a0 == 33, "R8 latency", 64'(cyc - a0), 64'd33);
          chk(in_ready, "R7 ready at done", {63'b0, in_ready}, 64'h1);
        end
      end
      prev_done = done;
      prev_dig  = digest;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done, "R1 done in reset", {63'b0, done}, 64'h0);
    chk(digest == 0, "R1 digest in reset", digest, 64'h0);
    chk(in_ready, "R1 ready in reset", {63'b0, in_ready}, 64'h1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!done && digest == 0, "R1 after release", digest, 64'h0);
    chk(in_ready, "R1 ready after release", {63'b0, in_ready}, 64'h1);

    send(64'h0, 64'h0, 64'h0, 0);
    send(64'hffffffffffffffff, 64'hffffffffffffffff, 64'hffffffffffffffff, 0);
    send(64'h0102030405060708, 64'h1112131415161718, 64'h0, 0);      // R2 R3 byte walk
    send(64'h1112131415161718, 64'h0102030405060708, 64'h0, 0);      // swapped operands
    send(64'h00000000000000ff, 64'h0, 64'h0123456789abcdef, 0);      // R3 low byte of A
    send(64'h0, 64'hff00000000000000, 64'h0123456789abcdef, 0);      // R3 top byte of B
    send(64'hdeadbeefcafef00d, 64'h0badc0de12345678, 64'h8000000000000001, 0); // R4 key
    send(64'hdeadbeefcafef00d, 64'h0badc0de12345678, 64'h8000000000000000, 0); // R5 lanes
    send(64'h13579bdf2468ace0, 64'hfedcba9876543210, 64'h5a5a5a5aa5a5a5a5, 20); // R7 busy
    send(64'ha5a5a5a5a5a5a5a5, 64'h5a5a5a5a5a5a5a5a, 64'hffff0000ffff0000, 0);
    send(64'h7, 64'h9, 64'h3c3c3c3c3c3c3c3c, 0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(n_done == n_sent, "R7 done count", 64'(n_done), 64'(n_sent));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule